// File: doc/BRIEF.md
# Eight-Opcode 8-bit Multi-Cycle CPU Core

This block is a small processor core that executes a compact instruction set of eight opcodes, each instruction one byte wide. It holds four 8-bit general registers, a three-flag condition code (negative, zero, positive) and an 8-bit program counter. Instructions come from an internal 256-word instruction memory. Loads and stores use an internal 256-word data memory. Both memories are filled through a write port before the core is started.

Each instruction passes through four states: fetch, decode, execute and writeback. Branches, loads and stores take their address from a register named in the instruction rather than from an offset. The immediate-load and address-forming instructions always write register 0. A run pulse starts execution from address 0. The core stops when it fetches the reserved word 0x00, or when it decodes an encoding whose reserved bits are not zero. A debug port reads back the registers, the PC and the flags.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous active-high reset sets all four registers to 0, sets PC to 0 and sets the flags to Z only (debug flags word 3'b010). halted and illegal are 0 after reset. The core stays idle, with PC unchanged, until run is sampled high.
- R2: The opcode is in bits [7:5]. ADD (000) and AND (001) compute DR = DR op B, where DR is in bits [4:3]. B is the register named by bits [1:0] when bit [2] is 0, and bits [1:0] sign-extended when bit [2] is 1.
- R3: NOT (111) writes DR (bits [4:3]) with the bitwise complement of its old value. Bits [2:0] must be 000.
- R4: LDImm (011) writes R0 with bits [4:0] sign-extended, and leaves R1 to R3 unchanged.
- R5: LEA (100) writes R0 with the address of the next instruction plus bits [4:0] sign-extended.
- R6: LD (101) loads register [4:3] from the data word at the address held in register [1:0]. ST (110) stores register [4:3] to the address held in register [1:0]. Bit [2] is 0 for both.
- R7: BR (010) has its N, Z and P mask in bits [4:2] and a target register in bits [1:0]. It sets PC to that register when any masked flag is set. Mask 000 never branches; mask 111 always branches.
- R8: ADD, AND, NOT, LDImm, LEA and LD set exactly one flag from the written value: N if bit 7 is set, Z if the value is zero, P otherwise. ST and BR leave the flags unchanged. The debug flags word is {N,Z,P} in bits [2:0].
- R9: Fetching the word 0x00 stops the core with halted=1 and illegal=0. PC is left one past the halt word and stays there.
- R10: An LD or ST with bit [2] set, or a NOT with bits [2:0] nonzero, stops the core with halted=1 and illegal=1. Its destination register is not written and no later instruction runs.
- R11: Every executed instruction takes exactly four clock cycles. halted rises 4k+2 cycles after the cycle in which run is sampled, where k is the number of instructions before the halt word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Starts execution from the idle state |
| prog_we | input | 1 | Memory preload write enable |
| prog_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| prog_addr | input | 8 | Preload address |
| prog_data | input | 8 | Preload data |
| dbg_sel | input | 3 | Debug select: 0-3 registers, 4 PC, 5 flags |
| dbg_data | output | 8 | Selected debug value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an illegal encoding |

## Verification
Arithmetic programs mix the register and immediate operand forms with operands of both signs. These tell correct sign extension apart from zero extension, and the DR-as-first-source rule apart from a swapped operand. A store followed by a reload, plus a load from a preloaded word, separates the address register from the data register. Branch programs try not-taken, conditionally taken and unconditional cases, each followed by counting instructions that a wrong branch would skip or execute. Reserved-bit violations, the halt word and a cycle count from run to halt check how the core stops and its per-instruction latency.

// File: rtl/tiny8_core.sv
module tiny8_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         prog_we,
  input  logic         prog_sel,
  input  logic [W-1:0] prog_addr,
  input  logic [W-1:0] prog_data,
  input  logic [2:0]   dbg_sel,
  output logic [W-1:0] dbg_data,
  output logic         halted,
  output logic         illegal
);
  localparam int DEPTH = 1 << W;
  localparam logic [2:0] OP_ADD = 3'd0, OP_AND = 3'd1, OP_BR  = 3'd2, OP_LDI = 3'd3,
                         OP_LEA = 3'd4, OP_LD  = 3'd5, OP_ST  = 3'd6, OP_NOT = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_EXEC, S_WB, S_DONE} state_t;

  state_t       st;
  logic [7:0]   imem [DEPTH];
  logic [W-1:0] dmem [DEPTH];
  logic [W-1:0] rf   [4];
  logic [7:0]   ir;
  logic [W-1:0] pc, res;
  logic [2:0]   nzp;
  logic         ill;

  wire [2:0]   op    = ir[7:5];
  wire [1:0]   dr    = ir[4:3];
  wire [1:0]   sr    = ir[1:0];
  wire [W-1:0] sx2   = {{(W-2){ir[1]}}, ir[1:0]};
  wire [W-1:0] sx5   = {{(W-5){ir[4]}}, ir[4:0]};
  wire [W-1:0] opb   = ir[2] ? sx2 : rf[sr];
  wire [W-1:0] maddr = rf[sr];
  wire         bad   = ((op == OP_LD || op == OP_ST) && ir[2]) ||
                       (op == OP_NOT && ir[2:0] != 3'b000);
  wire         wr_en = (op != OP_BR) && (op != OP_ST);
  wire [1:0]   wdst  = (op == OP_LDI || op == OP_LEA) ? 2'd0 : dr;
  wire         take  = |(ir[4:2] & nzp);

  assign halted  = (st == S_DONE);
  assign illegal = ill;

  always_comb begin
    case (dbg_sel)
      3'd0, 3'd1, 3'd2, 3'd3: dbg_data = rf[dbg_sel[1:0]];
      3'd4:                   dbg_data = pc;
      3'd5:                   dbg_data = {{(W-3){1'b0}}, nzp};
      default:                dbg_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (prog_we && !prog_sel) imem[prog_addr] <= prog_data[7:0];
  end

  always_ff @(posedge clk) begin
    if (st == S_EXEC && op == OP_ST) dmem[maddr] <= rf[dr];
    else if (prog_we && prog_sel)    dmem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      pc  <= '0;
      ir  <= '0;
      res <= '0;
      nzp <= 3'b010;
      ill <= 1'b0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE:  if (run) st <= S_FETCH;
        S_FETCH: begin
          ir <= imem[pc];
          pc <= pc + 1'b1;
          st <= S_DEC;
        end
        S_DEC: begin
          if (ir == 8'h00) st <= S_DONE;
          else if (bad) begin
            ill <= 1'b1;
            st  <= S_DONE;
          end else st <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_ADD:  res <= rf[dr] + opb;
            OP_AND:  res <= rf[dr] & opb;
            OP_LDI:  res <= sx5;
            OP_LEA:  res <= pc + sx5;
            OP_LD:   res <= dmem[maddr];
            OP_NOT:  res <= ~rf[dr];
            default: res <= res;
          endcase
          st <= S_WB;
        end
        S_WB: begin
          if (wr_en) begin
            rf[wdst] <= res;
            nzp <= res[W-1] ? 3'b100 : (res == '0) ? 3'b010 : 3'b001;
          end
          if (op == OP_BR && take) pc <= rf[sr];
          st <= S_FETCH;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !run) |=> (st == S_IDLE && $stable(pc))); // R1
  AST_R0_ONLY: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB && (op == OP_LDI || op == OP_LEA)) |=>
      ($stable(rf[1]) && $stable(rf[2]) && $stable(rf[3]))); // R4
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(nzp)); // R8
  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB && (op == OP_ST || op == OP_BR)) |=> $stable(nzp)); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE) |=> (halted && $stable(pc) && $stable(ill))); // R9
  AST_ILL_STOP: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && bad) |=> (illegal && halted)); // R10
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == W'($past(pc) + 1'b1))); // R11
endmodule

// File: tb/tiny8_core_test.sv
module tiny8_core_test;
  logic       clk = 0, rst = 1, run = 0, prog_we = 0, prog_sel = 0;
  logic [7:0] prog_addr = 0, prog_data = 0;
  logic [2:0] dbg_sel = 0;
  logic [7:0] dbg_data;
  logic       halted, illegal;
  int checks = 0, errors = 0, ptr = 0;

  tiny8_core uut (.clk(clk), .rst(rst), .run(run), .prog_we(prog_we), .prog_sel(prog_sel),
                  .prog_addr(prog_addr), .prog_data(prog_data), .dbg_sel(dbg_sel),
                  .dbg_data(dbg_data), .halted(halted), .illegal(illegal));

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk);
    @(negedge clk) rst = 0;
    ptr = 0;
  endtask

  task automatic pw(input logic sel, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_we = 1; prog_sel = sel; prog_addr = a; prog_data = d;
    @(negedge clk) prog_we = 0;
  endtask

  task automatic put(input logic [7:0] b);
    pw(0, ptr[7:0], b);
    ptr++;
  endtask

  task automatic go(output int n);
    @(negedge clk) run = 1;
    @(posedge clk);
    @(negedge clk) run = 0;
    n = 0;
    while (!halted && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk) dbg_sel = s;
    #1 v = dbg_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin rd(i[2:0], v); chk("R1 reg", v, 8'h00); end
    rd(4, v); chk("R1 pc idle", v, 8'h00);
    rd(5, v); chk("R1 flags", v, 8'h02);
    chk("R1 halted", {7'b0, halted}, 8'h00);
    chk("R1 illegal", {7'b0, illegal}, 8'h00);
  endtask

  task automatic t_arith();
    logic [7:0] v; int n;
    do_reset();
    put(8'h65); put(8'h08); put(8'h0D); put(8'h63); put(8'h28);
    put(8'h2E); put(8'h11); put(8'h16); put(8'h00);
    go(n);
    rd(0, v); chk("R2 r0", v, 8'h03);
    rd(1, v); chk("R2 and imm/reg r1", v, 8'h02);
    rd(2, v); chk("R2 add neg imm r2", v, 8'h00);
    rd(5, v); chk("R8 zero flag", v, 8'h02);
  endtask

  task automatic t_not_ldi();
    logic [7:0] v; int n;
    do_reset();
    put(8'h70); put(8'h08); put(8'h6F); put(8'h18); put(8'hE0); put(8'h00);
    go(n);
    rd(1, v); chk("R4 neg imm5", v, 8'hF0);
    rd(3, v); chk("R4 pos imm5 via r3", v, 8'h0F);
    rd(2, v); chk("R4 r2 untouched", v, 8'h00);
    rd(0, v); chk("R3 not", v, 8'hF0);
    rd(5, v); chk("R8 neg flag", v, 8'h04);
    rd(4, v); chk("R9 pc after halt", v, 8'h06);
    chk("R9 illegal low", {7'b0, illegal}, 8'h00);
  endtask

  task automatic t_lea();
    logic [7:0] v; int n;
    do_reset();
    put(8'h40); put(8'h40); put(8'h40); put(8'h9E); put(8'h08); put(8'h85); put(8'h00);
    go(n);
    rd(1, v); chk("R5 lea back", v, 8'h02);
    rd(0, v); chk("R5 lea fwd", v, 8'h0B);
    rd(4, v); chk("R7 mask 000 no branch pc", v, 8'h07);
    rd(5, v); chk("R8 pos flag", v, 8'h01);
  endtask

  task automatic t_mem();
    logic [7:0] v; int n;
    do_reset();
    pw(1, 8'h00, 8'h5A);
    put(8'h6A); put(8'h08); put(8'h79); put(8'hC1); put(8'hB1);
    put(8'hBB); put(8'hD1); put(8'h00);
    go(n);
    rd(2, v); chk("R6 store then load", v, 8'hF9);
    rd(3, v); chk("R6 preloaded load", v, 8'h5A);
    rd(5, v); chk("R8 st keeps flags", v, 8'h01);
  endtask

  task automatic t_branch();
    logic [7:0] v; int n;
    do_reset();
    put(8'h6D); put(8'h10); put(8'h6A); put(8'h18); put(8'h60);
    put(8'h56); put(8'h0D); put(8'h47); put(8'h0D); put(8'h0D);
    put(8'h5E); put(8'h0D); put(8'h0D); put(8'h00);
    go(n);
    rd(1, v); chk("R7 branch path count", v, 8'h01);
    rd(4, v); chk("R7 final pc", v, 8'h0E);
    rd(5, v); chk("R8 br keeps flags", v, 8'h01);
  endtask

  task automatic t_illegal();
    logic [7:0] v; int n;
    do_reset();
    put(8'h63); put(8'hAC); put(8'h10); put(8'h00);
    go(n);
    chk("R10 ld bit2 illegal", {6'b0, halted, illegal}, 8'h03);
    rd(1, v); chk("R10 ld dest kept", v, 8'h00);
    rd(2, v); chk("R10 no later instr", v, 8'h00);
    rd(4, v); chk("R10 pc", v, 8'h02);
    do_reset();
    put(8'h65); put(8'hE1); put(8'h00);
    go(n);
    chk("R10 not bits illegal", {7'b0, illegal}, 8'h01);
    rd(0, v); chk("R10 not dest kept", v, 8'h05);
  endtask

  task automatic t_timing();
    int n;
    do_reset();
    put(8'h61); put(8'h62); put(8'h63); put(8'h00);
    go(n);
    chk("R11 cycles to halt", n[7:0], 8'd14);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_not_ldi();
    t_lea();
    t_mem();
    t_branch();
    t_illegal();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule